// File: doc/BRIEF.md
# Bidirectional Parallel Port with Direction-Dependent Readback

This block is an 8-bit general-purpose parallel I/O port. A direction register and a data register sit behind a small register bus. The bus supports whole-register reads and writes, plus single-bit set and clear operations on the data register. Each bit drives an output-enable and an output level toward an external pad cell, and samples the pad's input level through a two-flop synchronizer.

Reads of the data register are chosen per bit by direction: an output bit returns the stored value, and an input bit returns the synchronized pin level. The single-bit operations are read-modify-write, so every input bit of the data register is overwritten with the pin level it currently sees.

A low-power request, combined with a pin-float control bit, turns off every output enable and gates the input buffers. This keeps a floating pad from toggling logic inside the block. The data register has no reset. Reset clears only the direction register, so software can load an output value before it enables any driver.

Top module: `bidir_port`

## Requirements
- R1: A direction bit of 1 asserts that bit's `padOe` and drives `padOut` from the stored data bit. A direction bit of 0 deasserts `padOe`.
- R2: A write to the data register (address 0) always stores the value, including its input bits. A stored input bit appears on `padOut` with `padOe` asserted once its direction bit becomes 1.
- R3: A read of the data register returns, for each bit, the stored bit when the direction bit is 1 and the sampled pin level (low = 0, high = 1) when it is 0. `rdData` updates on the clock edge that samples `rdEn` and holds its value otherwise.
- R4: A bit-set or bit-clear forces bit `bitIdx` of the data register to 1 or to 0. Other output bits keep their stored value, and every other input bit is loaded with its sampled pin level. If set and clear arrive together, clear is applied.
- R5: Reset clears the direction register to 0x00, so every `padOe` is 0. Reset also clears `rdData` to 0.
- R6: While `lpModeActive` and `pinFloatEn` are both 1, every `padOe` bit is 0 whatever the direction register holds.
- R7: Under the same condition, `padInBufEn` is 0 and the sampled input level is forced to 0, both for reads and for bit-set and bit-clear operations.
- R8: The pad inputs pass through two flops. A read strobed on the first or second edge after a pin change returns the old level, and a read on the third edge returns the new level.
- R9: A register write in the same cycle as a bit-set or bit-clear is applied, and the bit operation is dropped.
- R10: Address 0 selects the data register and address 1 the direction register. A read of address 1 returns the stored direction value unchanged.
- R11: `lpModeActive` with `pinFloatEn` at 0 has no effect on `padOe` or `padInBufEn`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| regAddr | input | 1 | Register select: 0 data, 1 direction |
| wrEn | input | 1 | Write strobe |
| wrData | input | 8 | Write value |
| rdEn | input | 1 | Read strobe |
| rdData | output | 8 | Read value, registered |
| bitSetEn | input | 1 | Set data bit `bitIdx` (read-modify-write) |
| bitClrEn | input | 1 | Clear data bit `bitIdx` (read-modify-write) |
| bitIdx | input | 3 | Target bit for set and clear |
| lpModeActive | input | 1 | Low-power mode request |
| pinFloatEn | input | 1 | Pin-float control for low-power mode |
| padIn | input | 8 | Pad input levels |
| padOut | output | 8 | Pad output levels |
| padOe | output | 8 | Pad output enables |
| padInBufEn | output | 1 | Pad input buffer enable |

## Verification
The bench builds the port at its default width of 8, which gives a 3-bit bit index. At this width the lowest and highest bit positions can both be targets of set and clear. Direction masks can split the port into an output nibble and an input nibble, so one read shows the stored half and the pin half side by side.

// File: rtl/bidir_port_pkg.sv
package bidir_port_pkg;

  // Strobes from control to datapath, one cycle wide.
  typedef struct packed {
    logic wrData;    // store bus value into data register
    logic wrDir;     // store bus value into direction register
    logic setBit;    // read-modify-write, target bit to 1
    logic clrBit;    // read-modify-write, target bit to 0
    logic rdReq;     // capture read value
    logic rdSelDir;  // read selects direction register
    logic hiZ;       // low-power pin float: outputs off, inputs gated
  } portStrobes_t;

endpackage

// File: rtl/bidir_port_ctrl.sv
module bidir_port_ctrl
  import bidir_port_pkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  logic         regAddr,
  input  logic         wrEn,
  input  logic         rdEn,
  input  logic         bitSetEn,
  input  logic         bitClrEn,
  input  logic         lpModeActive,
  input  logic         pinFloatEn,
  output portStrobes_t strb
);

  localparam logic ADDR_DATA = 1'b0;
  localparam logic ADDR_DIR  = 1'b1;

  logic bitOpAllowed;

  // A whole-register write takes precedence over the single-bit ops.
  assign bitOpAllowed = !wrEn;

  always_comb begin
    strb          = '0;
    strb.wrData   = wrEn && (regAddr == ADDR_DATA);
    strb.wrDir    = wrEn && (regAddr == ADDR_DIR);
    strb.clrBit   = bitOpAllowed && bitClrEn;
    strb.setBit   = bitOpAllowed && bitSetEn && !bitClrEn;
    strb.rdReq    = rdEn;
    strb.rdSelDir = (regAddr == ADDR_DIR);
    strb.hiZ      = lpModeActive && pinFloatEn;
  end

  AST_WRITE_WINS: assert property (@(posedge clk) disable iff (!rstN)
    wrEn |-> !(strb.setBit || strb.clrBit)); // R9
  AST_BITOP_ONEHOT: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strb.setBit, strb.clrBit, strb.wrData})); // R4

endmodule

// File: rtl/bidir_port_dp.sv
module bidir_port_dp
  import bidir_port_pkg::*;
#(
  parameter int WIDTH = 8,
  parameter int IDXW  = 3
) (
  input  logic             clk,
  input  logic             rstN,
  input  portStrobes_t     strb,
  input  logic [WIDTH-1:0] wrData,
  input  logic [IDXW-1:0]  bitIdx,
  input  logic [WIDTH-1:0] padIn,
  output logic [WIDTH-1:0] rdData,
  output logic [WIDTH-1:0] padOut,
  output logic [WIDTH-1:0] padOe,
  output logic             padInBufEn
);

  logic [WIDTH-1:0] dirReg;
  logic [WIDTH-1:0] dataReg;
  logic [WIDTH-1:0] syncA;
  logic [WIDTH-1:0] syncB;
  logic [WIDTH-1:0] gatedIn;
  logic [WIDTH-1:0] sampled;
  logic [WIDTH-1:0] portView;
  logic [WIDTH-1:0] rmwVal;
  logic [WIDTH-1:0] rdQ;
  logic             inBufOn;

  assign inBufOn = !strb.hiZ;
  assign gatedIn = padIn & {WIDTH{inBufOn}};
  assign sampled = syncB & {WIDTH{inBufOn}};

  // Pad input synchronizer
  always_ff @(posedge clk) begin
    if (!rstN) begin
      syncA <= '0;
      syncB <= '0;
    end else begin
      syncA <= gatedIn;
      syncB <= syncA;
    end
  end

  // Per-bit readback selection and read-modify-write value
  for (genvar i = 0; i < WIDTH; i++) begin : g_bit
    assign portView[i] = dirReg[i] ? dataReg[i] : sampled[i];
    assign rmwVal[i]   = (bitIdx == IDXW'(i)) ? strb.setBit : portView[i];
  end

  always_ff @(posedge clk) begin
    if (!rstN) dirReg <= '0;
    else if (strb.wrDir) dirReg <= wrData;
  end

  // Data register intentionally keeps its content through reset.
  always_ff @(posedge clk) begin
    if (strb.wrData) dataReg <= wrData;
    else if (strb.setBit || strb.clrBit) dataReg <= rmwVal;
  end

  always_ff @(posedge clk) begin
    if (!rstN) rdQ <= '0;
    else if (strb.rdReq) rdQ <= strb.rdSelDir ? dirReg : portView;
  end

  assign rdData     = rdQ;
  assign padOut     = dataReg;
  assign padOe      = dirReg & {WIDTH{!strb.hiZ}};
  assign padInBufEn = inBufOn;

  AST_HIZ_OE_OFF: assert property (@(posedge clk) disable iff (!rstN)
    strb.hiZ |-> (padOe == '0)); // R6
  AST_HIZ_INPUT_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    strb.hiZ |-> (sampled == '0) && !padInBufEn); // R7
  AST_WR_STORES: assert property (@(posedge clk) disable iff (!rstN)
    strb.wrData |=> (padOut == $past(wrData))); // R2
  AST_SET_TARGET: assert property (@(posedge clk) disable iff (!rstN)
    strb.setBit |=> padOut[$past(bitIdx)]); // R4
  AST_CLR_TARGET: assert property (@(posedge clk) disable iff (!rstN)
    strb.clrBit |=> !padOut[$past(bitIdx)]); // R4
  AST_DIR_READ: assert property (@(posedge clk) disable iff (!rstN)
    (strb.rdReq && strb.rdSelDir) |=> (rdData == $past(dirReg))); // R10
  AST_RD_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !strb.rdReq |=> $stable(rdData)); // R3
  AST_DIR_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !strb.wrDir |=> $stable(dirReg)); // R1

endmodule

// File: rtl/bidir_port.sv
module bidir_port
  import bidir_port_pkg::*;
#(
  parameter int WIDTH = 8,
  localparam int IDXW = (WIDTH > 1) ? $clog2(WIDTH) : 1
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             regAddr,
  input  logic             wrEn,
  input  logic [WIDTH-1:0] wrData,
  input  logic             rdEn,
  output logic [WIDTH-1:0] rdData,
  input  logic             bitSetEn,
  input  logic             bitClrEn,
  input  logic [IDXW-1:0]  bitIdx,
  input  logic             lpModeActive,
  input  logic             pinFloatEn,
  input  logic [WIDTH-1:0] padIn,
  output logic [WIDTH-1:0] padOut,
  output logic [WIDTH-1:0] padOe,
  output logic             padInBufEn
);

  portStrobes_t strb;

  bidir_port_ctrl u_ctrl (
    .clk          (clk),
    .rstN         (rstN),
    .regAddr      (regAddr),
    .wrEn         (wrEn),
    .rdEn         (rdEn),
    .bitSetEn     (bitSetEn),
    .bitClrEn     (bitClrEn),
    .lpModeActive (lpModeActive),
    .pinFloatEn   (pinFloatEn),
    .strb         (strb)
  );

  bidir_port_dp #(.WIDTH(WIDTH), .IDXW(IDXW)) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .strb       (strb),
    .wrData     (wrData),
    .bitIdx     (bitIdx),
    .padIn      (padIn),
    .rdData     (rdData),
    .padOut     (padOut),
    .padOe      (padOe),
    .padInBufEn (padInBufEn)
  );

endmodule

// File: tb/sim_bidir_port.sv
module sim_bidir_port;

  localparam int CLK_PERIOD = 10;
  localparam int W = 8;

  logic         clk = 1'b0;
  logic         rstN;
  logic         regAddr;
  logic         wrEn;
  logic [W-1:0] wrData;
  logic         rdEn;
  logic [W-1:0] rdData;
  logic         bitSetEn;
  logic         bitClrEn;
  logic [2:0]   bitIdx;
  logic         lpModeActive;
  logic         pinFloatEn;
  logic [W-1:0] padIn;
  logic [W-1:0] padOut;
  logic [W-1:0] padOe;
  logic         padInBufEn;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  bidir_port #(.WIDTH(W)) u0 (
    .clk(clk), .rstN(rstN), .regAddr(regAddr), .wrEn(wrEn), .wrData(wrData),
    .rdEn(rdEn), .rdData(rdData), .bitSetEn(bitSetEn), .bitClrEn(bitClrEn),
    .bitIdx(bitIdx), .lpModeActive(lpModeActive), .pinFloatEn(pinFloatEn),
    .padIn(padIn), .padOut(padOut), .padOe(padOe), .padInBufEn(padInBufEn)
  );

  task automatic check(string req, logic [W-1:0] act, logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic busWrite(logic addr, logic [W-1:0] val);
    regAddr = addr; wrData = val; wrEn = 1'b1;
    @(posedge clk); #1;
    wrEn = 1'b0;
  endtask

  task automatic busRead(logic addr, output logic [W-1:0] val);
    regAddr = addr; rdEn = 1'b1;
    @(posedge clk); #1;
    rdEn = 1'b0;
    val = rdData;
  endtask

  task automatic bitOp(bit doSet, logic [2:0] idx);
    bitIdx = idx; bitSetEn = doSet; bitClrEn = !doSet;
    @(posedge clk); #1;
    bitSetEn = 1'b0; bitClrEn = 1'b0;
  endtask

  task automatic settle();
    repeat (3) @(posedge clk);
    #1;
  endtask

  task automatic testReset();
    logic [W-1:0] v;
    check("R5 padOe after reset", padOe, 8'h00);
    check("R5 rdData after reset", rdData, 8'h00);
    check("R11 input buffer on", {7'b0, padInBufEn}, 8'h01);
    busRead(1'b1, v);
    check("R5 direction reads zero", v, 8'h00);
  endtask

  task automatic testDrive();
    busWrite(1'b0, 8'hA5);
    check("R1 no drive while inputs", padOe, 8'h00);
    busWrite(1'b1, 8'h0F);
    check("R1 low nibble enabled", padOe, 8'h0F);
    check("R2 stored input bits kept", padOut, 8'hA5);
    busWrite(1'b1, 8'hFF);
    check("R2 stored bits appear on output", padOe & padOut, 8'hA5);
    busWrite(1'b1, 8'h0F);
  endtask

  task automatic testReadMux();
    logic [W-1:0] v;
    padIn = 8'h3C;
    settle();
    busRead(1'b0, v);
    check("R3 per-bit readback", v, 8'h35);
    repeat (2) @(posedge clk);
    #1;
    check("R3 rdData holds without strobe", rdData, 8'h35);
  endtask

  task automatic testSync();
    logic [W-1:0] v;
    padIn = 8'hF0;
    busRead(1'b0, v);
    check("R8 first edge old level", v, 8'h35);
    busRead(1'b0, v);
    check("R8 second edge old level", v, 8'h35);
    busRead(1'b0, v);
    check("R8 third edge new level", v, 8'hF5);
  endtask

  task automatic testRmw();
    logic [W-1:0] v;
    // dir 0x0F, data A5, pins F0: view F5, set bit1 -> F7
    bitOp(1'b1, 3'd1);
    check("R4 set: input bits take pin level", padOut, 8'hF7);
    busWrite(1'b1, 8'hFF);
    bitOp(1'b0, 3'd7);
    check("R4 clear bit7, others kept", padOut, 8'h77);
    bitOp(1'b1, 3'd0);
    check("R4 set bit0 (already set)", padOut, 8'h77);
    bitIdx = 3'd3; bitSetEn = 1'b1; bitClrEn = 1'b1;
    @(posedge clk); #1;
    bitSetEn = 1'b0; bitClrEn = 1'b0;
    check("R4 set with clear applies clear", padOut, 8'h77 & ~8'h08);
    busRead(1'b0, v);
    check("R3 all-output readback", v, 8'h77 & ~8'h08);
  endtask

  task automatic testWriteWins();
    regAddr = 1'b0; wrData = 8'h00; wrEn = 1'b1;
    bitIdx = 3'd0; bitSetEn = 1'b1;
    @(posedge clk); #1;
    wrEn = 1'b0; bitSetEn = 1'b0;
    check("R9 write wins over set", padOut, 8'h00);
    regAddr = 1'b1; wrData = 8'hFF; wrEn = 1'b1;
    bitIdx = 3'd4; bitSetEn = 1'b1;
    @(posedge clk); #1;
    wrEn = 1'b0; bitSetEn = 1'b0;
    check("R9 direction write drops set", padOut, 8'h00);
  endtask

  task automatic testDirRead();
    logic [W-1:0] v;
    busWrite(1'b1, 8'h5A);
    busRead(1'b1, v);
    check("R10 direction readback", v, 8'h5A);
    check("R1 enables follow direction", padOe, 8'h5A);
  endtask

  task automatic testLowPower();
    logic [W-1:0] v;
    busWrite(1'b0, 8'h77);
    busWrite(1'b1, 8'hFF);
    lpModeActive = 1'b1; pinFloatEn = 1'b0;
    #1;
    check("R11 no float without control bit", padOe, 8'hFF);
    check("R11 buffer stays on", {7'b0, padInBufEn}, 8'h01);
    pinFloatEn = 1'b1;
    #1;
    check("R6 all enables off", padOe, 8'h00);
    check("R7 input buffer off", {7'b0, padInBufEn}, 8'h00);
    busWrite(1'b1, 8'h00);
    padIn = 8'hFF;
    settle();
    busRead(1'b0, v);
    check("R7 gated inputs read zero", v, 8'h00);
    bitOp(1'b1, 3'd2);
    check("R7 rmw sees zero inputs", padOut, 8'h04);
    lpModeActive = 1'b0; pinFloatEn = 1'b0;
    busWrite(1'b1, 8'hFF);
    check("R6 drive resumes after exit", padOe, 8'hFF);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    rstN = 1'b0; regAddr = 1'b0; wrEn = 1'b0; wrData = '0; rdEn = 1'b0;
    bitSetEn = 1'b0; bitClrEn = 1'b0; bitIdx = '0;
    lpModeActive = 1'b0; pinFloatEn = 1'b0; padIn = '0;
    repeat (3) @(posedge clk);
    #1 rstN = 1'b1;
    testReset();
    testDrive();
    testReadMux();
    testSync();
    testRmw();
    testWriteWins();
    testDirRead();
    testLowPower();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule